// File: doc/BRIEF.md
# Multi-Port PCM Highway Serializer

This block moves time-slotted PCM traffic between a small slot memory and up to four serial highway ports. All ports share one external bit clock and one frame sync. The bit clock and frame sync are oversampled by the system clock, and the block acts on their edges. Each port has a serial receive input, a serial transmit output with a separate output-enable, and an active-low slot indication. The indication is low in exactly the time slots in which that port drives its transmit line. A configuration word selects how many ports are used: one, two or four. The same frame bit counter then serves every active port, and the frame is shortened so that the slot memory is shared evenly among the active ports.

The host side writes transmit bytes and per-slot enable bits into the slot memory and reads back the received bytes. Both use one flat address, laid out as port × (slots per port) + slot. The transmit launch edge and the receive sampling edge are each configured separately. The bit clock may run at the data rate or at twice the data rate.

The framing controller is a state machine with three states:
- S_HUNT: waits for the first frame sync after reset.
- S_LEAD: the first bit-clock period of a bit. Used only in double-clock mode.
- S_TAIL: the period of a bit in which received data is sampled.

Its transitions are:
- T_LOCK: S_HUNT goes to bit 0 on a frame sync.
- T_HOLD: S_LEAD goes to S_TAIL on the next launch edge.
- T_ADVANCE: S_TAIL goes to the next bit, wrapping at the end of the frame.
- T_RESYNC: from any running state, a launch edge that sees the frame sync returns to bit 0 of slot 0.

Top module: `pcm_highway_if`

## Requirements
- R1: After reset, and until the first launch edge that sees the frame sync high, every port holds pcm_txd=1, pcm_txd_oe=0 and pcm_tsc_n=1.
- R2: A launch edge with the frame sync high starts bit 0 of slot 0. Slots are 8 bits long and sent MSB first. Port p in slot s transmits the byte stored at address p×(TOTAL_SLOTS/N)+s, where N is the number of active ports.
- R3: cfg_port_mode 0 gives N=1, 1 gives N=2, and 2 or 3 gives N=4. A frame has TOTAL_SLOTS/N slots, and the bit counter wraps to bit 0 at the end of the frame without a new frame sync. Ports numbered N or above stay idle (txd=1, oe=0, tsc_n=1).
- R4: In a slot whose enable bit at the same address is 1, the port drives pcm_txd_oe=1 and pcm_tsc_n=0. In any other slot it holds pcm_txd_oe=0, pcm_tsc_n=1 and pcm_txd=1.
- R5: cfg_tx_fall=0 launches bits on rising bit-clock edges. cfg_tx_fall=1 launches them on falling edges.
- R6: With cfg_double_clk=1, each bit lasts two bit-clock periods and is launched on the first launch edge of the pair.
- R7: Received bits are sampled while the bit is in S_TAIL. The sampling edge is falling when cfg_rx_fall=1 and rising otherwise; when this is the launch edge, the sample is taken just before the next bit begins. Each completed byte is stored MSB first at the slot's address and can be read on host_rdata.
- R8: A frame sync seen on a launch edge in the middle of a frame restarts the frame at bit 0 of slot 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the highway signals |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_port_mode | input | 2 | Number of active ports: 0 for one, 1 for two, 2 or 3 for four |
| cfg_double_clk | input | 1 | 1: bit clock runs at twice the data rate |
| cfg_tx_fall | input | 1 | 1: launch transmit bits on falling edges |
| cfg_rx_fall | input | 1 | 1: sample receive bits on falling edges |
| pcm_bclk | input | 1 | Highway bit clock |
| pcm_fsync | input | 1 | Frame sync, high on the launch edge of bit 0 |
| pcm_rxd | input | 4 | Serial receive data, one bit per port |
| pcm_txd | output | 4 | Serial transmit data, one bit per port |
| pcm_txd_oe | output | 4 | Transmit output enable, one bit per port |
| pcm_tsc_n | output | 4 | Active-low slot indication, one bit per port |
| host_addr | input | log2(TOTAL_SLOTS) | Flat slot address for host access |
| host_wdata | input | 8 | Write data: a transmit byte, or the enable in bit 0 |
| host_tx_we | input | 1 | Write host_wdata as the transmit byte at host_addr |
| host_en_we | input | 1 | Write host_wdata[0] as the slot enable at host_addr |
| host_rdata | output | 8 | Received byte at host_addr |

## Verification
The assertions assume three things about the inputs:
- The configuration changes only while reset is held.
- Each bit-clock level lasts at least three system clocks, so that every edge is seen once and data looped back from the transmit side has settled before it is sampled.
- The frame sync changes together with a launch edge and falls before the next one.

The bench keeps to these rules. It drives the bit clock at a fixed three-clock half period, raises the frame sync only with the launch level, and resets the block before each new configuration. It loops each port's transmit line back to its receive line, with an idle-high pull when the output is disabled. The received bytes can therefore be predicted from the transmit image and the enable bits.

// File: rtl/pcm_hwy_pkg.sv
package pcm_hwy_pkg;

    typedef enum logic [1:0] {
        S_HUNT = 2'd0,
        S_LEAD = 2'd1,
        S_TAIL = 2'd2
    } frame_state_t;

    // Port-mode code to log2 of the active port count.
    function automatic logic [1:0] port_shift(input logic [1:0] mode);
        logic [1:0] r;
        unique case (mode)
            2'd0:    r = 2'd0;
            2'd1:    r = 2'd1;
            default: r = 2'd2;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/pcm_edge_detect.sv
module pcm_edge_detect (
    input  logic clk,
    input  logic rst_n,
    input  logic bclk,
    input  logic fsync,
    input  logic tx_fall,
    input  logic rx_fall,
    output logic launch_ev,
    output logic sample_ev,
    output logic fsync_s
);
    logic bclk_s;
    logic bclk_d;
    logic rise;
    logic fall;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bclk_s  <= 1'b0;
            bclk_d  <= 1'b0;
            fsync_s <= 1'b0;
        end else begin
            bclk_s  <= bclk;
            bclk_d  <= bclk_s;
            fsync_s <= fsync;
        end
    end

    always_comb begin
        rise      = bclk_s & ~bclk_d;
        fall      = ~bclk_s & bclk_d;
        launch_ev = tx_fall ? fall : rise;
        sample_ev = rx_fall ? fall : rise;
    end

    // R5: a launch event is always a single-cycle pulse
    p_launch_pulse_r5: assert property (@(posedge clk) disable iff (!rst_n)
        launch_ev |=> !launch_ev);

endmodule

// File: rtl/pcm_frame_fsm.sv
module pcm_frame_fsm
    import pcm_hwy_pkg::*;
#(
    parameter int BW = 10
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          launch_ev,
    input  logic          fsync,
    input  logic          double_clk,
    input  logic [BW-1:0] frame_last,
    output frame_state_t  state,
    output logic [BW-1:0] bitpos,
    output logic          bit_start,
    output logic          running
);
    frame_state_t  nxt_state;
    logic [BW-1:0] nxt_bit;
    logic          nxt_start;
    frame_state_t  first_state;

    always_comb begin
        first_state = double_clk ? S_LEAD : S_TAIL;
        nxt_state   = state;
        nxt_bit     = bitpos;
        nxt_start   = 1'b0;
        if (launch_ev) begin
            unique case (state)
                S_HUNT: begin
                    if (fsync) begin           // T_LOCK
                        nxt_state = first_state;
                        nxt_bit   = '0;
                        nxt_start = 1'b1;
                    end
                end
                S_LEAD: begin
                    if (fsync) begin           // T_RESYNC
                        nxt_state = first_state;
                        nxt_bit   = '0;
                        nxt_start = 1'b1;
                    end else begin             // T_HOLD
                        nxt_state = S_TAIL;
                    end
                end
                S_TAIL: begin
                    nxt_state = first_state;
                    nxt_start = 1'b1;
                    if (fsync) begin           // T_RESYNC
                        nxt_bit = '0;
                    end else if (bitpos == frame_last) begin
                        nxt_bit = '0;          // T_ADVANCE with wrap
                    end else begin
                        nxt_bit = bitpos + 1'b1; // T_ADVANCE
                    end
                end
                default: begin
                    nxt_state = S_HUNT;
                    nxt_bit   = '0;
                end
            endcase
        end
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state  <= S_HUNT;
            bitpos <= '0;
        end else begin
            state  <= nxt_state;
            bitpos <= nxt_bit;
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_start <= 1'b0;
        end else begin
            bit_start <= nxt_start;
        end
    end

    assign running = (state != S_HUNT);

    p_bitpos_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
        bitpos <= frame_last);

    p_lead_needs_double_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_LEAD) |-> double_clk);

    p_resync_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_ev && fsync) |=> (bitpos == '0 && state != S_HUNT && bit_start));

    p_advance_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (launch_ev && !fsync && state == S_TAIL) |=>
        (bitpos == (($past(bitpos) == $past(frame_last)) ? '0 : $past(bitpos) + 1'b1)));

    p_hunt_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (state == S_HUNT && !(launch_ev && fsync)) |=> (state == S_HUNT));

endmodule

// File: rtl/pcm_port_lane.sv
module pcm_port_lane #(
    parameter int AW = 7
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          active,
    input  logic          running,
    input  logic          bit_start,
    input  logic          sample_ev,
    input  logic          in_tail,
    input  logic [2:0]    bit_idx,
    input  logic [AW-1:0] slot_addr,
    input  logic [7:0]    tx_byte,
    input  logic          slot_en,
    input  logic          rxd,
    output logic          txd,
    output logic          txd_oe,
    output logic          tsc_n,
    output logic          rx_we,
    output logic [AW-1:0] rx_addr,
    output logic [7:0]    rx_byte
);
    logic       rxd_q;
    logic [6:0] shreg;

    // Transmit side: loads the new bit one cycle after the bit starts.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            txd    <= 1'b1;
            txd_oe <= 1'b0;
            tsc_n  <= 1'b1;
        end else if (!active || !running) begin
            txd    <= 1'b1;
            txd_oe <= 1'b0;
            tsc_n  <= 1'b1;
        end else if (bit_start) begin
            txd_oe <= slot_en;
            tsc_n  <= ~slot_en;
            txd    <= slot_en ? tx_byte[3'd7 - bit_idx] : 1'b1;
        end
    end

    // Receive side: samples before the bit counter moves on.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rxd_q   <= 1'b1;
            shreg   <= '0;
            rx_we   <= 1'b0;
            rx_addr <= '0;
            rx_byte <= '0;
        end else begin
            rxd_q <= rxd;
            rx_we <= 1'b0;
            if (active && in_tail && sample_ev) begin
                shreg <= {shreg[5:0], rxd_q};
                if (bit_idx == 3'd7) begin
                    rx_we   <= 1'b1;
                    rx_addr <= slot_addr;
                    rx_byte <= {shreg, rxd_q};
                end
            end
        end
    end

    p_hunt_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !running |=> (!txd_oe && tsc_n && txd));

    p_idle_port_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !active |=> (!txd_oe && tsc_n && txd));

    p_rx_in_tail_r7: assert property (@(posedge clk) disable iff (!rst_n)
        rx_we |-> ($past(in_tail) && $past(sample_ev)));

    p_off_slot_high_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !txd_oe |-> txd);

endmodule

// File: rtl/pcm_slot_mem.sv
module pcm_slot_mem #(
    parameter int DEPTH = 128,
    parameter int NP    = 4,
    localparam int AW   = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [AW-1:0]         host_addr,
    input  logic [7:0]            host_wdata,
    input  logic                  host_tx_we,
    input  logic                  host_en_we,
    output logic [7:0]            host_rdata,
    input  logic [NP-1:0][AW-1:0] rd_addr,
    output logic [NP-1:0][7:0]    tx_byte,
    output logic [NP-1:0]         slot_en,
    input  logic [NP-1:0]         rx_we,
    input  logic [NP-1:0][AW-1:0] rx_addr,
    input  logic [NP-1:0][7:0]    rx_byte
);
    logic [7:0]       tx_mem [DEPTH];
    logic [7:0]       rx_mem [DEPTH];
    logic [DEPTH-1:0] en_bits;

    always_ff @(posedge clk) begin
        if (host_tx_we) begin
            tx_mem[host_addr] <= host_wdata;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_bits <= '0;
        end else if (host_en_we) begin
            en_bits[host_addr] <= host_wdata[0];
        end
    end

    always_ff @(posedge clk) begin
        for (int p = 0; p < NP; p++) begin
            if (rx_we[p]) begin
                rx_mem[rx_addr[p]] <= rx_byte[p];
            end
        end
    end

    generate
        for (genvar p = 0; p < NP; p++) begin : g_rd
            assign tx_byte[p] = tx_mem[rd_addr[p]];
            assign slot_en[p] = en_bits[rd_addr[p]];
        end
    endgenerate

    assign host_rdata = rx_mem[host_addr];

endmodule

// File: rtl/pcm_highway_if.sv
module pcm_highway_if
    import pcm_hwy_pkg::*;
#(
    parameter int TOTAL_SLOTS = 128,
    localparam int AW = $clog2(TOTAL_SLOTS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [1:0]    cfg_port_mode,
    input  logic          cfg_double_clk,
    input  logic          cfg_tx_fall,
    input  logic          cfg_rx_fall,
    input  logic          pcm_bclk,
    input  logic          pcm_fsync,
    input  logic [3:0]    pcm_rxd,
    output logic [3:0]    pcm_txd,
    output logic [3:0]    pcm_txd_oe,
    output logic [3:0]    pcm_tsc_n,
    input  logic [AW-1:0] host_addr,
    input  logic [7:0]    host_wdata,
    input  logic          host_tx_we,
    input  logic          host_en_we,
    output logic [7:0]    host_rdata
);
    localparam int NP = 4;
    localparam int BW = AW + 3;

    logic          launch_ev;
    logic          sample_ev;
    logic          fsync_s;
    frame_state_t  state;
    logic [BW-1:0] bitpos;
    logic [BW-1:0] frame_last;
    logic          bit_start;
    logic          running;
    logic [1:0]    shift;
    logic [AW-1:0] slot_idx;

    logic [NP-1:0][AW-1:0] lane_addr;
    logic [NP-1:0][7:0]    tx_byte;
    logic [NP-1:0]         slot_en;
    logic [NP-1:0]         rx_we;
    logic [NP-1:0][AW-1:0] rx_addr;
    logic [NP-1:0][7:0]    rx_byte;

    assign shift      = port_shift(cfg_port_mode);
    assign frame_last = {BW{1'b1}} >> shift;
    assign slot_idx   = bitpos[BW-1:3];

    pcm_edge_detect u_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .bclk      (pcm_bclk),
        .fsync     (pcm_fsync),
        .tx_fall   (cfg_tx_fall),
        .rx_fall   (cfg_rx_fall),
        .launch_ev (launch_ev),
        .sample_ev (sample_ev),
        .fsync_s   (fsync_s)
    );

    pcm_frame_fsm #(.BW(BW)) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .launch_ev  (launch_ev),
        .fsync      (fsync_s),
        .double_clk (cfg_double_clk),
        .frame_last (frame_last),
        .state      (state),
        .bitpos     (bitpos),
        .bit_start  (bit_start),
        .running    (running)
    );

    pcm_slot_mem #(.DEPTH(TOTAL_SLOTS), .NP(NP)) u_mem (
        .clk        (clk),
        .rst_n      (rst_n),
        .host_addr  (host_addr),
        .host_wdata (host_wdata),
        .host_tx_we (host_tx_we),
        .host_en_we (host_en_we),
        .host_rdata (host_rdata),
        .rd_addr    (lane_addr),
        .tx_byte    (tx_byte),
        .slot_en    (slot_en),
        .rx_we      (rx_we),
        .rx_addr    (rx_addr),
        .rx_byte    (rx_byte)
    );

    generate
        for (genvar p = 0; p < NP; p++) begin : g_lane
            logic active;
            assign active       = (p < (1 << shift));
            assign lane_addr[p] = (AW'(p) << (AW - int'(shift))) | slot_idx;

            pcm_port_lane #(.AW(AW)) u_lane (
                .clk       (clk),
                .rst_n     (rst_n),
                .active    (active),
                .running   (running),
                .bit_start (bit_start),
                .sample_ev (sample_ev),
                .in_tail   (state == S_TAIL),
                .bit_idx   (bitpos[2:0]),
                .slot_addr (lane_addr[p]),
                .tx_byte   (tx_byte[p]),
                .slot_en   (slot_en[p]),
                .rxd       (pcm_rxd[p]),
                .txd       (pcm_txd[p]),
                .txd_oe    (pcm_txd_oe[p]),
                .tsc_n     (pcm_tsc_n[p]),
                .rx_we     (rx_we[p]),
                .rx_addr   (rx_addr[p]),
                .rx_byte   (rx_byte[p])
            );
        end
    endgenerate

endmodule

// File: tb/pcm_highway_if_test.sv
module pcm_highway_if_test;
    localparam int TS = 128;
    localparam int H  = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] cfg_port_mode = 2'd0;
    logic       cfg_double_clk = 1'b0;
    logic       cfg_tx_fall = 1'b0;
    logic       cfg_rx_fall = 1'b0;
    logic       pcm_bclk = 1'b0;
    logic       pcm_fsync = 1'b0;
    logic [3:0] pcm_rxd;
    logic [3:0] pcm_txd;
    logic [3:0] pcm_txd_oe;
    logic [3:0] pcm_tsc_n;
    logic [6:0] host_addr = '0;
    logic [7:0] host_wdata = '0;
    logic       host_tx_we = 1'b0;
    logic       host_en_we = 1'b0;
    logic [7:0] host_rdata;

    int   checks = 0;
    int   fails  = 0;
    bit   done   = 0;
    logic [7:0] tx_img [TS];
    bit         en_img [TS];
    int   nports = 1;
    int   slots  = TS;
    bit   dbl    = 0;
    bit   txf    = 0;

    always #10 clk = ~clk;

    // Loopback with idle-high pull when the output is disabled
    assign pcm_rxd = pcm_txd | ~pcm_txd_oe;

    pcm_highway_if uut (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_port_mode  (cfg_port_mode),
        .cfg_double_clk (cfg_double_clk),
        .cfg_tx_fall    (cfg_tx_fall),
        .cfg_rx_fall    (cfg_rx_fall),
        .pcm_bclk       (pcm_bclk),
        .pcm_fsync      (pcm_fsync),
        .pcm_rxd        (pcm_rxd),
        .pcm_txd        (pcm_txd),
        .pcm_txd_oe     (pcm_txd_oe),
        .pcm_tsc_n      (pcm_tsc_n),
        .host_addr      (host_addr),
        .host_wdata     (host_wdata),
        .host_tx_we     (host_tx_we),
        .host_en_we     (host_en_we),
        .host_rdata     (host_rdata)
    );

    task automatic chk(input string req, input string what, input int got, input int exp);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, got, exp);
        end
    endtask

    task automatic do_reset(input int mode, input bit d, input bit tf, input bit rf);
        @(negedge clk);
        rst_n          = 1'b0;
        cfg_port_mode  = mode[1:0];
        cfg_double_clk = d;
        cfg_tx_fall    = tf;
        cfg_rx_fall    = rf;
        nports         = (mode == 0) ? 1 : (mode == 1) ? 2 : 4;
        slots          = TS / nports;
        dbl            = d;
        txf            = tf;
        pcm_bclk       = tf;   // idle level opposite to the launch level
        pcm_fsync      = 1'b0;
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
    endtask

    task automatic load_mem(input int seed);
        for (int a = 0; a < TS; a++) begin
            tx_img[a] = 8'((a * 37 + seed * 11 + 5) & 255);
            en_img[a] = (((a * 7 + seed) % 5) != 0);
            host_addr  = 7'(a);
            host_wdata = tx_img[a];
            host_tx_we = 1'b1;
            @(negedge clk);
            host_tx_we = 1'b0;
            host_wdata = {7'd0, en_img[a]};
            host_en_we = 1'b1;
            @(negedge clk);
            host_en_we = 1'b0;
        end
    endtask

    task automatic period(input bit fs);
        pcm_fsync = fs;
        pcm_bclk  = ~txf;
        repeat (H) @(negedge clk);
        pcm_fsync = 1'b0;
        pcm_bclk  = txf;
        repeat (H) @(negedge clk);
    endtask

    task automatic check_idle(input string req);
        for (int p = 0; p < 4; p++) begin
            chk(req, "idle txd", int'(pcm_txd[p]), 1);
            chk(req, "idle oe", int'(pcm_txd_oe[p]), 0);
            chk(req, "idle tsc_n", int'(pcm_tsc_n[p]), 1);
        end
    endtask

    task automatic run_bits(input int start, input int count, input bit fs_first, input string tag);
        int fb;
        fb = slots * 8;
        for (int k = 0; k < count; k++) begin
            int idx;
            idx = (start + k) % fb;
            period(fs_first && (k == 0));
            if (dbl) period(1'b0);
            for (int p = 0; p < 4; p++) begin
                if (p >= nports) begin
                    chk("R3", "inactive oe", int'(pcm_txd_oe[p]), 0);
                    chk("R3", "inactive tsc_n", int'(pcm_tsc_n[p]), 1);
                    chk("R3", "inactive txd", int'(pcm_txd[p]), 1);
                end else begin
                    int a;
                    a = p * slots + idx / 8;
                    if (en_img[a]) begin
                        chk(tag, "txd", int'(pcm_txd[p]), int'(tx_img[a][7 - (idx % 8)]));
                        chk("R4", "enabled oe", int'(pcm_txd_oe[p]), 1);
                        chk("R4", "enabled tsc_n", int'(pcm_tsc_n[p]), 0);
                    end else begin
                        chk("R4", "disabled oe", int'(pcm_txd_oe[p]), 0);
                        chk("R4", "disabled tsc_n", int'(pcm_tsc_n[p]), 1);
                        chk("R4", "disabled txd", int'(pcm_txd[p]), 1);
                    end
                end
            end
        end
    endtask

    task automatic check_rx(input string tag);
        for (int a = 0; a < TS; a++) begin
            host_addr = 7'(a);
            @(negedge clk);
            chk(tag, "rx byte", int'(host_rdata), en_img[a] ? int'(tx_img[a]) : 8'hFF);
        end
    endtask

    // R1: reset state and quiet hunting without frame sync
    task automatic t_reset;
        do_reset(2, 0, 0, 1);
        check_idle("R1");
        load_mem(9);
        repeat (4) period(1'b0);
        check_idle("R1");
    endtask

    // R2, R7: one port, full frame, rx sampled on the opposite edge
    task automatic t_single;
        do_reset(0, 0, 0, 1);
        load_mem(1);
        run_bits(0, TS * 8, 1'b1, "R2");
        period(1'b0);
        check_rx("R7");
    endtask

    // R5, R3: four ports, falling launch, wrap without a second sync
    task automatic t_quad_fall_wrap;
        do_reset(3, 0, 1, 1);
        load_mem(2);
        run_bits(0, (TS / 4) * 8, 1'b1, "R5");
        run_bits(0, (TS / 4) * 8, 1'b0, "R3");
        period(1'b0);
        check_rx("R7");
    endtask

    // R6: two ports, double-rate bit clock, sampling on the launch edge
    task automatic t_dual_double;
        do_reset(1, 1, 0, 0);
        load_mem(3);
        run_bits(0, (TS / 2) * 8, 1'b1, "R6");
        period(1'b0);
        check_rx("R6");
    endtask

    // R8: frame sync in the middle of a frame
    task automatic t_resync;
        do_reset(2, 0, 0, 1);
        load_mem(4);
        run_bits(0, 37, 1'b1, "R8");
        run_bits(0, (TS / 4) * 8, 1'b1, "R8");
        period(1'b0);
        check_rx("R8");
    endtask

    initial begin
        t_reset;
        t_single;
        t_quad_fall_wrap;
        t_dual_double;
        t_resync;
        if (!done) begin
            done = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            fails++;
            $display("FAIL watchdog expired before all requirement checks finished");
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

endmodule